// File: doc/BRIEF.md
# Memory Bandwidth Throttle Controller

This block sits beside a DRAM controller and decides, cycle by cycle, whether memory traffic must be slowed and by how much. Four trip sources are watched: a read-transfer counter kept separately for every rank, a write-transfer counter for the whole controller, a level input from an external memory-module temperature sensor and a level input from the on-die temperature sensor. A 4-bit enable field switches any combination of them on. The enables are: bit 3 for the rank read counters, bit 2 for the write counter, bit 1 for the module sensor and bit 0 for the on-die sensor. Bandwidth is counted over repeating sampling windows whose length is programmable in clock cycles.

Trips are handled by two paths. The rank path takes the read counters and the module sensor and throttles all traffic. The write path takes the write counter and the on-die sensor. A write-counter trip throttles all traffic and an on-die sensor trip throttles only writes. Each path is a three-state machine: `ST_IDLE`, `ST_CNT_HOLD` (a counter trip is latched) and `ST_THERM_HOLD` (a sensor trip is latched). The transitions are as follows. IDLE goes to THERM_HOLD on a sensor trip, or to CNT_HOLD on a counter trip when no sensor trip is present. A hold state is kept through two window boundaries. At the second boundary the state re-evaluates: it goes to THERM_HOLD if the sensor is still tripped, to CNT_HOLD if the counter tripped in that window, and to IDLE otherwise. Either hold state drops to IDLE when both enables of its path are cleared.

A throttle setting is one byte. The upper nibble gives N, the number of granted slots, and the lower nibble gives M, the period in cycles. A throttled path grants a request only in the first N cycles of every M. A high-priority graphics read is always granted.

Top module: `mem_throttle_ctrl`

## Requirements
- R1: With the enable field at 0000 (the reset value), the block never throttles. `thr_active` is 0, `thr_duty` is 0 and every valid request is granted. A source whose enable bit is 0 never causes a throttle.
- R2: A window lasts `win_len` cycles. All transfer counters restart at each window boundary, so transfers from two different windows never add up to a trip.
- R3: The write counter trips when the number of writes in one window reaches (`win_len` × `wr_thresh`) >> 4. A threshold of 0 never trips. A write-counter trip throttles all traffic using `wr_cnt_duty`.
- R4: Reads are counted per rank, selected by `rd_rank`. The rank path trips when any single rank reaches (`win_len` × `rd_thresh`) >> 4 reads within a window. It then throttles all traffic using `rd_cnt_duty`.
- R5: The module sensor input passes through two synchronizing flip-flops. A rise on the input makes `thr_active` go high on the third clock edge after the rise. The block then throttles all traffic using `mod_th_duty`.
- R6: An on-die sensor trip throttles writes only, using `die_th_duty`. Reads stay fully granted.
- R7: If a sensor trip and a counter trip on the same path appear in the same cycle, the sensor setting is taken.
- R8: Once a path has latched a trip, its setting stays fixed until the second window boundary after the latch, even if the other source of that path trips meanwhile.
- R9: At the end of a hold, a path re-latches if its sensor is still tripped (sensor first) or if its counter tripped in that window. Otherwise it releases.
- R10: While a path throttles, requests it covers are granted only in cycles whose phase within the M-cycle period is below N. The phase starts at 0 when the path latches.
- R11: A valid high-priority graphics read (`req_gfx_hp`=1, `req_write`=0) is always granted.
- R12: `thr_active` is 1 while either path throttles. `thr_duty` shows the rank-path setting when the rank path is active, otherwise the write-path setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_en | input | 4 | Source enables: [3] rank read counters, [2] write counter, [1] module sensor, [0] on-die sensor |
| win_len | input | WIN_W | Sampling window length in cycles (at least 1) |
| rd_thresh | input | THR_W | Read threshold, in sixteenths of `win_len` |
| wr_thresh | input | THR_W | Write threshold, in sixteenths of `win_len` |
| rd_cnt_duty | input | 8 | Setting for a read-counter trip, {N, M} |
| wr_cnt_duty | input | 8 | Setting for a write-counter trip, {N, M} |
| mod_th_duty | input | 8 | Setting for a module sensor trip, {N, M} |
| die_th_duty | input | 8 | Setting for an on-die sensor trip, {N, M} |
| rd_xfer | input | 1 | One read transfer this cycle |
| rd_rank | input | RANK_W | Rank of that read transfer |
| wr_xfer | input | 1 | One write transfer this cycle |
| mod_therm_async | input | 1 | Module sensor trip level, asynchronous |
| die_therm_async | input | 1 | On-die sensor trip level, asynchronous |
| req_valid | input | 1 | A request wants a slot this cycle |
| req_write | input | 1 | The request is a write |
| req_gfx_hp | input | 1 | The request is a high-priority graphics read |
| req_grant | output | 1 | The request may issue this cycle |
| thr_active | output | 1 | Throttling is in force |
| thr_duty | output | 8 | Setting in force, {N, M}; 0 when idle |

## Verification
The interesting collisions are a sensor trip and a counter trip landing in the same cycle on one path, and a second source tripping while the first is still being held. The first case is set up with a counter limit of one transfer: the single write is timed so that the counter result and the second synchronizer stage both become visible on the same edge, and `thr_duty` must then show the sensor setting. The second case latches the write counter first and then raises the on-die sensor. The setting must stay at the counter value until two boundaries have passed, and must switch to the sensor value at the re-evaluation.

// File: rtl/thr_pkg.sv
`timescale 1ns/1ps
package thr_pkg;
    localparam int DUTY_W = 4;

    typedef struct packed {
        logic [DUTY_W-1:0] on_slots;
        logic [DUTY_W-1:0] period;
    } duty_t;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_CNT_HOLD   = 2'd1,
        ST_THERM_HOLD = 2'd2
    } path_st_e;

    localparam logic [1:0] HOLD_WINDOWS = 2'd2;
endpackage

// File: rtl/thr_sync.sv
`timescale 1ns/1ps
module thr_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign q_sync = stage2;
endmodule

// File: rtl/thr_window.sv
`timescale 1ns/1ps
module thr_window #(
    parameter int WIN_W     = 16,
    parameter int THR_W     = 8,
    parameter int FRAC_W    = 4,
    parameter int NUM_RANKS = 2,
    parameter int RANK_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [WIN_W-1:0]  win_len,
    input  logic [THR_W-1:0]  rd_thresh,
    input  logic [THR_W-1:0]  wr_thresh,
    input  logic              rd_xfer,
    input  logic [RANK_W-1:0] rd_rank,
    input  logic              wr_xfer,
    output logic              boundary,
    output logic              rd_trip,
    output logic              rd_hit,
    output logic              wr_trip,
    output logic              wr_hit
);
    localparam int CNT_W = WIN_W + THR_W;

    logic [WIN_W-1:0] win_cnt;
    logic [CNT_W-1:0] rd_lim;
    logic [CNT_W-1:0] wr_lim;
    logic [CNT_W-1:0] wr_cnt;
    logic [NUM_RANKS-1:0] rk_trip;
    logic rd_seen;
    logic wr_seen;

    assign boundary = run && (win_cnt >= (win_len - WIN_W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n || !run || boundary) win_cnt <= '0;
        else                            win_cnt <= win_cnt + WIN_W'(1);
    end

    assign rd_lim = (CNT_W'(win_len) * CNT_W'(rd_thresh)) >> FRAC_W;
    assign wr_lim = (CNT_W'(win_len) * CNT_W'(wr_thresh)) >> FRAC_W;

    for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
        logic [CNT_W-1:0] rk_cnt;
        logic             rk_ev;
        assign rk_ev = rd_xfer && (rd_rank == RANK_W'(r));
        always_ff @(posedge clk) begin
            if (!rst_n || !rd_en) rk_cnt <= '0;
            else if (boundary)    rk_cnt <= CNT_W'(rk_ev);
            else                  rk_cnt <= rk_cnt + CNT_W'(rk_ev);
        end
        assign rk_trip[r] = rd_en && (rd_lim != '0) && (rk_cnt >= rd_lim);

        a_r2_rank_restart: assert property (@(posedge clk) disable iff (!rst_n)
            (boundary && !rk_ev) |=> (rk_cnt == '0));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !wr_en) wr_cnt <= '0;
        else if (boundary)    wr_cnt <= CNT_W'(wr_xfer);
        else                  wr_cnt <= wr_cnt + CNT_W'(wr_xfer);
    end

    assign rd_trip = |rk_trip;
    assign wr_trip = wr_en && (wr_lim != '0) && (wr_cnt >= wr_lim);

    always_ff @(posedge clk) begin
        if (!rst_n || boundary) begin
            rd_seen <= 1'b0;
            wr_seen <= 1'b0;
        end else begin
            rd_seen <= rd_seen | rd_trip;
            wr_seen <= wr_seen | wr_trip;
        end
    end

    assign rd_hit = rd_seen | rd_trip;
    assign wr_hit = wr_seen | wr_trip;

    a_r2_write_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !wr_xfer) |=> (wr_cnt == '0));
    a_r1_write_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !wr_trip);
    a_r3_zero_never: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thresh == '0) |-> !wr_trip);
endmodule

// File: rtl/thr_path_fsm.sv
`timescale 1ns/1ps
module thr_path_fsm
    import thr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_cnt,
    input  logic     en_th,
    input  logic     cnt_trip,
    input  logic     cnt_hit,
    input  logic     th_trip,
    input  logic     boundary,
    output path_st_e state,
    output logic     active
);
    path_st_e   nxt_state;
    logic [1:0] hold_left;
    logic [1:0] nxt_hold;
    logic       th_act;
    logic       cnt_act;
    logic       hit_act;
    logic       path_on;

    assign path_on = en_cnt || en_th;
    assign th_act  = en_th && th_trip;
    assign cnt_act = en_cnt && cnt_trip;
    assign hit_act = en_cnt && cnt_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_left <= '0;
        end else begin
            state     <= nxt_state;
            hold_left <= nxt_hold;
        end
    end

    always_comb begin
        nxt_state = state;
        nxt_hold  = hold_left;
        if (!path_on) begin
            nxt_state = ST_IDLE;
            nxt_hold  = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (th_act) begin
                        nxt_state = ST_THERM_HOLD;
                        nxt_hold  = HOLD_WINDOWS;
                    end else if (cnt_act) begin
                        nxt_state = ST_CNT_HOLD;
                        nxt_hold  = HOLD_WINDOWS;
                    end
                end
                ST_CNT_HOLD, ST_THERM_HOLD: begin
                    if (boundary) begin
                        if (hold_left > 2'd1) begin
                            nxt_hold = hold_left - 2'd1;
                        end else if (th_act) begin
                            nxt_state = ST_THERM_HOLD;
                            nxt_hold  = HOLD_WINDOWS;
                        end else if (hit_act) begin
                            nxt_state = ST_CNT_HOLD;
                            nxt_hold  = HOLD_WINDOWS;
                        end else begin
                            nxt_state = ST_IDLE;
                            nxt_hold  = '0;
                        end
                    end
                end
                default: begin
                    nxt_state = ST_IDLE;
                    nxt_hold  = '0;
                end
            endcase
        end
    end

    always_comb begin
        active = (state != ST_IDLE);
    end

    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ((state != ST_IDLE) && !boundary && path_on) |=> (state == $past(state)));
    a_r8_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> (hold_left != 2'd0));
    a_r7_therm_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && th_act) |=> (state == ST_THERM_HOLD));
endmodule

// File: rtl/thr_duty.sv
`timescale 1ns/1ps
module thr_duty
    import thr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  duty_t duty,
    output logic  slot
);
    logic [DUTY_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            phase <= '0;
        else if ((DUTY_W+1)'(phase) + 1'b1 >= (DUTY_W+1)'(duty.period))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    assign slot = active && (phase < duty.on_slots);

    a_r10_phase_start: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (phase == '0));
    a_r10_zero_slots: assert property (@(posedge clk) disable iff (!rst_n)
        (duty.on_slots == '0) |-> !slot);
endmodule

// File: rtl/mem_throttle_ctrl.sv
`timescale 1ns/1ps
module mem_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int WIN_W     = 16,
    parameter int THR_W     = 8,
    parameter int FRAC_W    = 4,
    parameter int NUM_RANKS = 2,
    parameter int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            mode_en,
    input  logic [WIN_W-1:0]      win_len,
    input  logic [THR_W-1:0]      rd_thresh,
    input  logic [THR_W-1:0]      wr_thresh,
    input  logic [2*DUTY_W-1:0]   rd_cnt_duty,
    input  logic [2*DUTY_W-1:0]   wr_cnt_duty,
    input  logic [2*DUTY_W-1:0]   mod_th_duty,
    input  logic [2*DUTY_W-1:0]   die_th_duty,
    input  logic                  rd_xfer,
    input  logic [RANK_W-1:0]     rd_rank,
    input  logic                  wr_xfer,
    input  logic                  mod_therm_async,
    input  logic                  die_therm_async,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_gfx_hp,
    output logic                  req_grant,
    output logic                  thr_active,
    output logic [2*DUTY_W-1:0]   thr_duty
);
    localparam int EN_RD  = 3;
    localparam int EN_WR  = 2;
    localparam int EN_MOD = 1;
    localparam int EN_DIE = 0;

    logic [1:0] therm_sync;
    logic       boundary, rd_trip, rd_hit, wr_trip, wr_hit;
    path_st_e   rk_st, wp_st;
    logic       rk_act, wp_act;
    duty_t      rk_set, wp_set;
    logic       rk_slot, wp_slot;
    logic       wp_all_traffic;
    logic       hp_read;

    thr_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({mod_therm_async, die_therm_async}),
        .q_sync  (therm_sync)
    );

    thr_window #(
        .WIN_W(WIN_W), .THR_W(THR_W), .FRAC_W(FRAC_W),
        .NUM_RANKS(NUM_RANKS), .RANK_W(RANK_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (|mode_en),
        .rd_en     (mode_en[EN_RD]),
        .wr_en     (mode_en[EN_WR]),
        .win_len   (win_len),
        .rd_thresh (rd_thresh),
        .wr_thresh (wr_thresh),
        .rd_xfer   (rd_xfer),
        .rd_rank   (rd_rank),
        .wr_xfer   (wr_xfer),
        .boundary  (boundary),
        .rd_trip   (rd_trip),
        .rd_hit    (rd_hit),
        .wr_trip   (wr_trip),
        .wr_hit    (wr_hit)
    );

    thr_path_fsm u_rank_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_cnt   (mode_en[EN_RD]),
        .en_th    (mode_en[EN_MOD]),
        .cnt_trip (rd_trip),
        .cnt_hit  (rd_hit),
        .th_trip  (therm_sync[1]),
        .boundary (boundary),
        .state    (rk_st),
        .active   (rk_act)
    );

    thr_path_fsm u_write_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_cnt   (mode_en[EN_WR]),
        .en_th    (mode_en[EN_DIE]),
        .cnt_trip (wr_trip),
        .cnt_hit  (wr_hit),
        .th_trip  (therm_sync[0]),
        .boundary (boundary),
        .state    (wp_st),
        .active   (wp_act)
    );

    always_comb begin
        rk_set = (rk_st == ST_THERM_HOLD) ? duty_t'(mod_th_duty) : duty_t'(rd_cnt_duty);
        wp_set = (wp_st == ST_THERM_HOLD) ? duty_t'(die_th_duty) : duty_t'(wr_cnt_duty);
        wp_all_traffic = (wp_st == ST_CNT_HOLD);
    end

    thr_duty u_rank_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (rk_act),
        .duty   (rk_set),
        .slot   (rk_slot)
    );

    thr_duty u_write_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (wp_act),
        .duty   (wp_set),
        .slot   (wp_slot)
    );

    always_comb begin
        hp_read    = req_gfx_hp && !req_write;
        req_grant  = req_valid && (hp_read ||
                     ((!rk_act || rk_slot) &&
                      (!wp_act || !(req_write || wp_all_traffic) || wp_slot)));
        thr_active = rk_act || wp_act;
        if (rk_act)      thr_duty = rk_set;
        else if (wp_act) thr_duty = wp_set;
        else             thr_duty = '0;
    end

    a_r1_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en == 4'b0000) |=> !thr_active);
    a_r11_hp_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_gfx_hp && !req_write) |-> req_grant);
    a_r12_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_active && req_valid) |-> req_grant);
    a_r6_reads_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((wp_st == ST_THERM_HOLD) && !rk_act && req_valid && !req_write) |-> req_grant);
endmodule

// File: tb/mem_throttle_ctrl_tb_top.sv
`timescale 1ns/1ps
module mem_throttle_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] mode_en;
    logic [15:0] win_len;
    logic [7:0] rd_thresh, wr_thresh;
    logic [7:0] rd_cnt_duty, wr_cnt_duty, mod_th_duty, die_th_duty;
    logic       rd_xfer, wr_xfer;
    logic [0:0] rd_rank;
    logic       mod_therm_async, die_therm_async;
    logic       req_valid, req_write, req_gfx_hp;
    logic       req_grant, thr_active;
    logic [7:0] thr_duty;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] RD_SET  = 8'h04;
    localparam logic [7:0] WR_SET  = 8'h24;
    localparam logic [7:0] MOD_SET = 8'h34;
    localparam logic [7:0] DIE_SET = 8'h14;

    always #4 clk = ~clk;

    mem_throttle_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .win_len(win_len),
        .rd_thresh(rd_thresh), .wr_thresh(wr_thresh),
        .rd_cnt_duty(rd_cnt_duty), .wr_cnt_duty(wr_cnt_duty),
        .mod_th_duty(mod_th_duty), .die_th_duty(die_th_duty),
        .rd_xfer(rd_xfer), .rd_rank(rd_rank), .wr_xfer(wr_xfer),
        .mod_therm_async(mod_therm_async), .die_therm_async(die_therm_async),
        .req_valid(req_valid), .req_write(req_write), .req_gfx_hp(req_gfx_hp),
        .req_grant(req_grant), .thr_active(thr_active), .thr_duty(thr_duty)
    );

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        summary_and_end();
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d (0x%0h), expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [3:0] m);
        rst_n = 1'b0; mode_en = m; win_len = 16'd8;
        rd_thresh = 8'd8; wr_thresh = 8'd8;
        rd_cnt_duty = RD_SET; wr_cnt_duty = WR_SET;
        mod_th_duty = MOD_SET; die_th_duty = DIE_SET;
        rd_xfer = 0; wr_xfer = 0; rd_rank = '0;
        mod_therm_async = 0; die_therm_async = 0;
        req_valid = 0; req_write = 0; req_gfx_hp = 0;
        ticks(3);
        rst_n = 1'b1;
        ticks(1);
    endtask

    // Polls once per cycle; returns number of polls until active, or 0.
    task automatic wait_active(input int limit, output int polls);
        polls = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (thr_active) begin polls = i; break; end
        end
    endtask

    // Drives a request for n cycles starting now and counts grants.
    task automatic count_grants(input int n, input logic wr, input logic hp, output int g);
        g = 0;
        req_valid = 1; req_write = wr; req_gfx_hp = hp;
        for (int i = 0; i < n; i++) begin
            #1;
            if (req_grant) g++;
            @(negedge clk);
        end
        req_valid = 0; req_write = 0; req_gfx_hp = 0;
    endtask

    task automatic t_reset_and_off();
        int g;
        do_reset(4'b0000);
        chk("R1 reset thr_active", thr_active, 0);
        chk("R1 reset thr_duty", thr_duty, 0);
        wr_xfer = 1; rd_xfer = 1; mod_therm_async = 1; die_therm_async = 1;
        ticks(20);
        chk("R1 mode 0000 never throttles", thr_active, 0);
        count_grants(4, 1'b1, 1'b0, g);
        chk("R1 mode 0000 grants all", g, 4);
        wr_xfer = 0; rd_xfer = 0; mod_therm_async = 0; die_therm_async = 0;
    endtask

    task automatic t_disabled_sources();
        do_reset(4'b1000);
        wr_xfer = 1; die_therm_async = 1; mod_therm_async = 1;
        ticks(20);
        chk("R1 disabled sources ignored", thr_active, 0);
        wr_xfer = 0; die_therm_async = 0; mod_therm_async = 0;
    endtask

    task automatic t_write_counter();
        int p, g;
        do_reset(4'b0100);
        for (int i = 0; i < 3; i++) begin wr_xfer = 1; ticks(1); end
        wr_xfer = 0; ticks(10);
        for (int i = 0; i < 3; i++) begin wr_xfer = 1; ticks(1); end
        wr_xfer = 0; ticks(10);
        chk("R2 counts restart per window", thr_active, 0);
        wr_xfer = 1;
        wait_active(12, p);
        wr_xfer = 0;
        chk("R3 write counter trips", (p != 0), 1);
        chk("R3 write counter setting", thr_duty, WR_SET);
        count_grants(8, 1'b0, 1'b0, g);
        chk("R3 R10 write counter throttles reads 2 of 4", g, 4);
        chk("R8 still held one window later", thr_active, 1);
        ticks(11);
        chk("R9 released with no source", thr_active, 0);
    endtask

    task automatic t_zero_threshold();
        do_reset(4'b0100);
        wr_thresh = 8'd0;
        wr_xfer = 1; ticks(24); wr_xfer = 0;
        chk("R3 zero threshold never trips", thr_active, 0);
    endtask

    task automatic t_rank_counter();
        int p, g;
        do_reset(4'b1000);
        for (int i = 0; i < 6; i++) begin rd_xfer = 1; rd_rank = 1'(i); ticks(1); end
        rd_xfer = 0; ticks(10);
        chk("R4 ranks counted separately", thr_active, 0);
        rd_xfer = 1; rd_rank = 1'b1;
        wait_active(12, p);
        rd_xfer = 0;
        chk("R4 single rank trips", (p != 0), 1);
        chk("R4 rank counter setting", thr_duty, RD_SET);
        count_grants(4, 1'b0, 1'b0, g);
        chk("R10 zero slots blocks reads", g, 0);
        count_grants(4, 1'b0, 1'b1, g);
        chk("R11 hp graphics reads granted", g, 4);
    endtask

    task automatic t_module_sensor();
        int p, g;
        do_reset(4'b0010);
        mod_therm_async = 1;
        wait_active(8, p);
        chk("R5 two-flop sync latency", p, 3);
        chk("R5 module sensor setting", thr_duty, MOD_SET);
        count_grants(8, 1'b1, 1'b0, g);
        chk("R5 R10 writes granted 3 of 4", g, 6);
        mod_therm_async = 0;
    endtask

    task automatic t_die_sensor();
        int p, g;
        do_reset(4'b0001);
        die_therm_async = 1;
        wait_active(8, p);
        chk("R6 on-die sensor setting", thr_duty, DIE_SET);
        count_grants(8, 1'b0, 1'b0, g);
        chk("R6 reads not throttled", g, 8);
        count_grants(8, 1'b1, 1'b0, g);
        chk("R6 writes granted 1 of 4", g, 2);
        die_therm_async = 0;
    endtask

    task automatic t_simultaneous();
        do_reset(4'b0101);
        wr_thresh = 8'd2;
        ticks(20);
        die_therm_async = 1;
        ticks(1);
        wr_xfer = 1;
        ticks(1);
        wr_xfer = 0;
        ticks(1);
        chk("R7 both trip same cycle active", thr_active, 1);
        chk("R7 sensor setting wins", thr_duty, DIE_SET);
        die_therm_async = 0;
    endtask

    task automatic t_first_latch();
        int p;
        do_reset(4'b0101);
        wr_xfer = 1;
        wait_active(12, p);
        wr_xfer = 0;
        die_therm_async = 1;
        chk("R8 counter latched first", thr_duty, WR_SET);
        ticks(5);
        chk("R8 later sensor trip ignored in hold", thr_duty, WR_SET);
        ticks(14);
        chk("R9 re-latch active", thr_active, 1);
        chk("R9 re-latch picks sensor", thr_duty, DIE_SET);
        die_therm_async = 0;
    endtask

    task automatic t_select();
        int p;
        do_reset(4'b0011);
        mod_therm_async = 1; die_therm_async = 1;
        wait_active(8, p);
        ticks(2);
        chk("R12 rank path shown first", thr_duty, MOD_SET);
        mod_therm_async = 0;
        ticks(50);
        chk("R12 write path shown after rank release", thr_duty, DIE_SET);
        die_therm_async = 0;
    endtask

    initial begin
        t_reset_and_off();
        t_disabled_sources();
        t_write_counter();
        t_zero_threshold();
        t_rank_counter();
        t_module_sensor();
        t_die_sensor();
        t_simultaneous();
        t_first_latch();
        t_select();
        summary_and_end();
    end
endmodule